// File: doc/BRIEF.md
# Start-Stop Character Transmitter with Stop-Bit Deletion

This block turns bytes written by a host into a serial bit stream. A single holding register takes one byte. It answers at two write addresses. A byte written to the normal address goes out with the programmed number of stop bits. A byte written to the shortening address asks for a shorter stop period, which lets the link run slightly faster than nominal.

In the phase-shift start-stop mode, the shortening address removes one whole stop bit. In the frequency-shift start-stop mode, it trims the last stop bit to seven eighths of a bit. In the synchronous mode, the shortening address acts as the normal address.

Each bit lasts eight pulses of a sub-bit tick input. When the holding register is empty at a character boundary, the line stays at mark level in whole-bit steps until new data arrives. A built-in window limits how often shortening is granted: at most once in eight characters in the basic range, or once in four in the extended range.

Top module: `async_char_tx`

## Requirements
- R1: During and right after reset, `txd` is 1, `ready` is 1 and `overrun` is 0.
- R2: In the start-stop modes (`mode` 0 or 1), a character written to address 0xE3 is sent as follows, with each bit lasting 8 `sub_tick` pulses: a start bit at 0, then 8 data bits LSB first, then 1 stop bit at 1 (`two_stop`=0) or 2 stop bits (`two_stop`=1).
- R3: With `mode`=0 and `two_stop`=1, a granted write to address 0xE4 is sent with a single stop bit.
- R4: With `mode`=0 and `two_stop`=0, a write to address 0xE4 is sent as a normal character with one stop bit.
- R5: With `mode`=1, a granted write to address 0xE4 ends its final stop bit after 7 `sub_tick` pulses instead of 8.
- R6: With `mode`=2, characters carry no start or stop bits. Their data bits follow each other with no gap, a write to 0xE4 gives the same stream as a write to 0xE3, and the line sends 1 bits while no data is waiting.
- R7: If the holding register is empty when a stop period ends, the line holds 1 in whole bits of 8 `sub_tick` pulses. The next start bit begins at the first bit boundary after the write.
- R8: A shortening request is granted only if at least 7 (`ext_range`=0) or 3 (`ext_range`=1) characters have been loaded since the last granted one. The first request after reset is granted. A refused request is sent as a normal character.
- R9: `ready` falls in the cycle after an accepted write. It rises again when the character moves to the shifter at a bit boundary.
- R10: A write while `ready` is 0 is dropped, and `overrun` pulses for one cycle. A write to any address other than 0xE3 or 0xE4 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write address (0xE3 normal, 0xE4 shortened) |
| wr_data | input | 8 | Character to send |
| mode | input | 2 | 0 phase-shift start-stop, 1 frequency-shift start-stop, 2 synchronous |
| two_stop | input | 1 | Programmed stop count: 0 gives one, 1 gives two |
| ext_range | input | 1 | Selects the 1-in-4 shortening window instead of 1-in-8 |
| sub_tick | input | 1 | Sub-bit timing pulse, 8 per bit |
| txd | output | 1 | Serial data output, idles at 1 |
| ready | output | 1 | Holding register can accept a character |
| overrun | output | 1 | One-cycle pulse on a dropped write |

## Verification
`txd` changes in the clock cycle after the `sub_tick` edge that ends a bit. The bench therefore records `txd` on the falling edge that follows each tick and compares it against an expected waveform with one entry per sub-tick. That waveform is built arithmetically from the bytes, the addresses and the stop rules. `ready` and `overrun` take effect one clock after the write strobe is registered, so they are read on the falling edge right after that rising edge. For the underrun case, the bench computes the expected start of the delayed character by rounding the write's tick index up to the next bit boundary.

// File: rtl/async_char_tx.sv
module async_char_tx #(
  parameter logic [7:0] ADDR_NORM  = 8'hE3,
  parameter logic [7:0] ADDR_SHORT = 8'hE4,
  parameter int DBITS     = 8,
  parameter int SUBDIV    = 8,
  parameter int WIN_BASIC = 8,
  parameter int WIN_EXT   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] mode,
  input  logic       two_stop,
  input  logic       ext_range,
  input  logic       sub_tick,
  output logic       txd,
  output logic       ready,
  output logic       overrun
);
  localparam int SW = $clog2(SUBDIV);
  localparam int BW = $clog2(DBITS);
  localparam int CW = $clog2(WIN_BASIC);
  localparam logic [1:0] M_PSK = 2'd0, M_FSK = 2'd1, M_SYNC = 2'd2;
  localparam logic [CW-1:0] SINCE_MAX = CW'(WIN_BASIC - 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} st_t;

  st_t             st;
  logic [SW-1:0]   sub;
  logic [BW-1:0]   bitn;
  logic [DBITS-1:0] hold_q, sh_q;
  logic            hold_full, hold_mark, stop_more, cur_short;
  logic [CW-1:0]   since;

  logic wr_hit, accept, sync, grant, last_stop, bit_end, data_done, advance, load;
  logic [SW-1:0] len_m1;
  logic [CW-1:0] win_need;

  assign sync      = (mode == M_SYNC);
  assign wr_hit    = wr_en && (wr_addr == ADDR_NORM || wr_addr == ADDR_SHORT);
  assign accept    = wr_hit && !hold_full;
  assign win_need  = ext_range ? CW'(WIN_EXT - 1) : CW'(WIN_BASIC - 1);
  assign grant     = hold_mark && !sync && (since >= win_need) && !(mode == M_PSK && !two_stop);
  assign last_stop = (st == S_STOP) && !stop_more;
  assign len_m1    = (last_stop && cur_short) ? SW'(SUBDIV - 2) : SW'(SUBDIV - 1);
  assign bit_end   = sub_tick && (sub == len_m1);
  assign data_done = (st == S_DATA) && (bitn == BW'(DBITS - 1));
  assign advance   = bit_end && (st == S_IDLE || last_stop || (data_done && sync));
  assign load      = advance && hold_full;

  assign txd   = (st == S_START) ? 1'b0 : (st == S_DATA) ? sh_q[0] : 1'b1;
  assign ready = !hold_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      sub       <= '0;
      bitn      <= '0;
      hold_q    <= '0;
      sh_q      <= '0;
      hold_full <= 1'b0;
      hold_mark <= 1'b0;
      stop_more <= 1'b0;
      cur_short <= 1'b0;
      since     <= SINCE_MAX;
      overrun   <= 1'b0;
    end else begin
      overrun <= wr_hit && hold_full;
      if (accept) begin
        hold_q    <= wr_data;
        hold_mark <= (wr_addr == ADDR_SHORT);
        hold_full <= 1'b1;
      end
      if (load) hold_full <= 1'b0;
      if (sub_tick) sub <= bit_end ? '0 : sub + 1'b1;
      if (load) begin
        sh_q      <= hold_q;
        bitn      <= '0;
        st        <= sync ? S_DATA : S_START;
        cur_short <= grant && (mode == M_FSK);
        stop_more <= two_stop && !(grant && mode == M_PSK);
        since     <= grant ? '0 : (since == SINCE_MAX ? since : since + 1'b1);
      end else if (advance) begin
        st        <= S_IDLE;
        cur_short <= 1'b0;
      end else if (bit_end) begin
        case (st)
          S_START: begin
            st   <= S_DATA;
            bitn <= '0;
          end
          S_DATA: begin
            if (data_done) st <= S_STOP;
            else begin
              bitn <= bitn + 1'b1;
              sh_q <= sh_q >> 1;
            end
          end
          S_STOP: stop_more <= 1'b0;
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/async_char_tx_chk.sv
module async_char_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_addr,
  input logic       sub_tick,
  input logic       txd,
  input logic       ready,
  input logic       overrun
);
  logic hit;
  assign hit = wr_en && (wr_addr == 8'hE3 || wr_addr == 8'hE4);

  // R10
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(hit && !ready));

  // R9
  ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ready) |=> !ready);

  // R9
  ready_rise_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(sub_tick));

  // R2
  txd_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd) |-> $past(sub_tick));
endmodule

bind async_char_tx async_char_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .sub_tick(sub_tick), .txd(txd), .ready(ready), .overrun(overrun)
);

// File: tb/tb_async_char_tx.sv
`timescale 1ns/1ps
module tb_async_char_tx;
  logic clk = 0, rst_n = 0, wr_en = 0, two_stop = 0, ext_range = 0, sub_tick = 0;
  logic [7:0] wr_addr = 0, wr_data = 0;
  logic [1:0] mode = 0;
  logic txd, ready, overrun;

  async_char_tx dut (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0, tickn = 0, epos = 0, total = 0;
  logic samp [0:2047];
  logic expv [0:2047];
  logic [7:0] cd [0:15];
  logic cf [0:15];
  logic ovr_seen;

  always @(negedge clk) begin
    if (!rst_n) begin
      sub_tick = 0;
      tickn = 0;
    end else begin
      if (sub_tick && tickn < 2047) begin
        tickn = tickn + 1;
        samp[tickn] = txd;
      end
      sub_tick = ~sub_tick;
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp_i);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp_i);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 0;
    repeat (3) @(negedge clk);
    @(posedge clk) rst_n <= 1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    ovr_seen = overrun;
    wr_en = 0;
  endtask

  task automatic push(input logic v, input int n);
    for (int i = 0; i < n; i++) begin
      if (epos < 2048) expv[epos] = v;
      epos++;
    end
  endtask

  task automatic push_char(input logic [7:0] d, input int stop_len);
    if (mode != 2) push(0, 8);
    for (int b = 0; b < 8; b++) push(d[b], 8);
    push(1, stop_len);
  endtask

  function automatic int stop_len_of(input bit granted);
    if (mode == 2) return 0;
    if (mode == 0) return (two_stop && !granted) ? 16 : 8;
    return (two_stop ? 16 : 8) - (granted ? 1 : 0);
  endfunction

  task automatic build(input int n);
    int since = 7;
    epos = 1;
    push(1, 7);
    for (int i = 0; i < n; i++) begin
      bit g;
      int need = ext_range ? 3 : 7;
      g = cf[i] && mode != 2 && since >= need && !(mode == 0 && !two_stop);
      since = g ? 0 : (since < 7 ? since + 1 : 7);
      push_char(cd[i], stop_len_of(g));
    end
    push(1, 24);
    total = epos - 1;
  endtask

  task automatic compare(input string rq);
    int bad = -1;
    while (tickn < total) @(negedge clk);
    for (int k = 1; k <= total; k++)
      if (bad < 0 && samp[k] !== expv[k]) bad = k;
    chk(bad < 0, rq, bad < 0 ? 0 : 1000 * bad + int'(samp[bad]),
        bad < 0 ? 0 : 1000 * bad + int'(expv[bad]));
  endtask

  task automatic run_case(input string rq, input int n);
    build(n);
    do_reset();
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!ready) @(negedge clk);
      wr(cf[i] ? 8'hE4 : 8'hE3, cd[i]);
    end
    compare(rq);
  endtask

  task automatic fill(input int n, input bit all_short, input int seed);
    for (int i = 0; i < n; i++) begin
      cd[i] = 8'(seed + 37 * i + (i << 4));
      cf[i] = all_short ? 1'b1 : 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", tickn, total);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1;
    chk(txd === 1 && ready === 1 && overrun === 0, "R1 in reset", {txd, ready, overrun}, 3'b110);
    do_reset();
    @(negedge clk);
    chk(txd === 1 && ready === 1 && overrun === 0, "R1 after reset", {txd, ready, overrun}, 3'b110);

    mode = 0; two_stop = 0; fill(3, 0, 8'hA5); run_case("R2 psk one stop", 3);
    mode = 0; two_stop = 1; fill(3, 0, 8'h3C); run_case("R2 psk two stop", 3);
    mode = 1; two_stop = 1; fill(3, 0, 8'h81); run_case("R2 fsk two stop", 3);
    mode = 0; two_stop = 1; fill(3, 0, 8'h5A); cf[0] = 1; run_case("R3 psk deleted stop", 3);
    mode = 0; two_stop = 0; fill(3, 1, 8'hC3); run_case("R4 psk single stop kept", 3);
    mode = 1; two_stop = 0; fill(3, 0, 8'h0F); cf[0] = 1; run_case("R5 fsk short stop", 3);
    mode = 1; two_stop = 1; fill(3, 0, 8'hF0); cf[1] = 1; run_case("R5 fsk short second stop", 3);
    mode = 2; two_stop = 1; fill(4, 0, 8'h96); cf[1] = 1; cf[3] = 1; run_case("R6 sync stream", 4);
    mode = 1; two_stop = 0; ext_range = 0; fill(10, 1, 8'h11); run_case("R8 basic window", 10);
    mode = 0; two_stop = 1; ext_range = 1; fill(10, 1, 8'h22); run_case("R8 extended window", 10);
    ext_range = 0;

    // R7 underrun: A in flight, B written after tick 100
    mode = 0; two_stop = 0;
    cd[0] = 8'h6B; cd[1] = 8'hD2;
    epos = 1;
    push(1, 7);
    push_char(cd[0], 8);
    push(1, 88 + 8 * ((100 + 1 - 88 + 7) / 8) - epos);
    push_char(cd[1], 8);
    push(1, 24);
    total = epos - 1;
    do_reset();
    wr(8'hE3, cd[0]);
    wait (tickn == 100);
    wr_en = 1; wr_addr = 8'hE3; wr_data = cd[1];
    @(negedge clk) wr_en = 0;
    compare("R7 underrun mark bits");

    // R9 / R10
    mode = 1; two_stop = 1;
    cd[0] = 8'h96; cf[0] = 0;
    build(1);
    do_reset();
    wr(8'hE5, 8'h3C);
    chk(ready === 1 && ovr_seen === 0, "R10 foreign address ignored", {ready, ovr_seen}, 2'b10);
    wr(8'hE3, cd[0]);
    chk(ready === 0, "R9 ready falls after write", ready, 0);
    wr(8'hE4, 8'h55);
    chk(ovr_seen === 1, "R10 overrun pulse", ovr_seen, 1);
    @(negedge clk);
    chk(overrun === 0, "R10 overrun one cycle", overrun, 0);
    while (tickn < 9) @(negedge clk);
    chk(ready === 1, "R9 ready back after load", ready, 1);
    compare("R10 dropped write not sent");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule